// File: doc/BRIEF.md
# Reference-Counted Pad Power Sequencer

This block owns the shared power domain of a group of I/O pads that serve more than one PHY. Clients ask it to enable or disable a PHY, naming the PHY by an identifier. It keeps a count of the PHYs currently in use. It walks the three domain controls through an ordered sequence only when the first user arrives or the last user leaves. Those controls are core-voltage-down, early clamp and clamp. Every step of that sequence is followed by a settle interval counted in clock cycles.

Between the domain sequence and the response, the block hands over to the per-PHY bring-up or shutdown logic through a start/done handshake and waits for its result. On enable, the domain comes up before the PHY is started. On disable, the PHY is shut down before the domain goes down. Only one request is in flight at a time: a ready/valid handshake holds off new requests while a sequence runs, and a one-cycle done pulse with an error flag closes every request.

Top module: `pad_pwr_seq`

## Requirements
- R1: After reset, rail_vcore_down, rail_clamp_early and rail_clamp are all 1 (domain off), use_count is 0, req_ready is 1 and busy is 0.
- R2: An accepted enable while use_count is 0 first clears rail_clamp, then rail_clamp_early, then rail_vcore_down. Consecutive changes are at least SETTLE_CYC = CLK_MHZ*SETTLE_US cycles apart, and phy_start follows the last change by at least SETTLE_CYC cycles.
- R3: An accepted, successful disable while use_count is 1 first sets rail_vcore_down, then rail_clamp_early, then rail_clamp, with the same minimum spacing. use_count then becomes 0.
- R4: An accepted enable while use_count is between 1 and its maximum changes no rail. It runs the PHY handshake with phy_on=1 and raises use_count by one.
- R5: An accepted, successful disable while use_count is above 1 changes no rail and lowers use_count by one.
- R6: phy_start is a one-cycle pulse. phy_sel carries the request identifier and phy_on carries the request direction (1 enable, 0 disable). For an enable, phy_start only occurs with all three rails at 0. For a disable, phy_start precedes every rail change of that request.
- R7: Identifier 0 (PCIe) and 1 (SATA) are accepted. Identifiers 2 and 3 end with done=1, error=1, no phy_start, no rail change and no change of use_count.
- R8: When phy_done arrives with phy_fail=1, the request ends with done=1 and error=1. use_count is unchanged and no further rail changes occur for that request.
- R9: A disable with use_count 0, or an enable with use_count at its maximum 2^CNT_W-1, ends with done=1 and error=1. It causes no phy_start, no rail change and no change of use_count.
- R10: A request is taken on a clock edge where req_valid and req_ready are both 1. req_ready is 0 and busy is 1 from then until the request completes. Each request ends with exactly one done pulse one cycle long, and error is valid in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can take a request |
| req_enable | input | 1 | 1 = enable PHY, 0 = disable PHY |
| req_phy_id | input | 2 | PHY identifier (0 PCIe, 1 SATA) |
| phy_start | output | 1 | One-cycle start pulse to per-PHY logic |
| phy_on | output | 1 | Direction for per-PHY logic (1 bring-up) |
| phy_sel | output | 2 | PHY addressed by phy_start |
| phy_done | input | 1 | Per-PHY step finished |
| phy_fail | input | 1 | Per-PHY step failed, valid with phy_done |
| rail_vcore_down | output | 1 | Core-voltage-down control, 1 = down |
| rail_clamp_early | output | 1 | Early clamp enable |
| rail_clamp | output | 1 | Clamp enable |
| busy | output | 1 | A request is in progress |
| done | output | 1 | One-cycle completion pulse |
| error | output | 1 | Request rejected or failed, valid with done |
| use_count | output | CNT_W | Number of PHYs in use |

## Verification
The bench goes after the count edges. It enables from zero and disables at one, where a block that tested the count at the wrong moment would skip the rail sequence or run it for a second user. It also rejects a disable at zero and a fourth enable with a two-bit count; a block without those guards would wrap use_count and later tear the domain down under an active PHY. Rail timestamps are compared against the PHY start time to catch a swapped step order, a missing settle interval, or a PHY started before the clamps are released. Failing PHY replies and unknown identifiers are checked to leave the count and the rails alone, which catches a counter updated before the PHY result is known.

// File: rtl/pad_pwr_pkg.sv
// Shared types for the pad power sequencer.
// Assumes three domain rails, indexed so that the power-up order is 0,1,2.
package pad_pwr_pkg;
    localparam int NUM_RAILS = 3;
    localparam int RAIL_CLAMP = 0;
    localparam int RAIL_EARLY = 1;
    localparam int RAIL_VCORE = 2;
    localparam int LAST_STEP = NUM_RAILS - 1;

    localparam logic [1:0] PHY_ID_PCIE = 2'd0;
    localparam logic [1:0] PHY_ID_SATA = 2'd1;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_STEP,
        ST_SETTLE,
        ST_PHY_GO,
        ST_PHY_WAIT,
        ST_RESP
    } seq_state_t;

    // Rail touched by a given step: forward order going up, reverse going down.
    function automatic logic [1:0] rail_of_step(input logic dir_up, input logic [1:0] step);
        return dir_up ? step : 2'(LAST_STEP - int'(step));
    endfunction

    function automatic logic phy_id_known(input logic [1:0] id);
        return (id == PHY_ID_PCIE) || (id == PHY_ID_SATA);
    endfunction
endpackage

// File: rtl/pad_settle_timer.sv
// Settle timer: after a start pulse, raises tick for one cycle SETTLE_CYC
// cycles later. Assumes SETTLE_CYC >= 1 and no restart while running.
module pad_settle_timer #(
    parameter int SETTLE_CYC = 20000,
    localparam int CYC_W = $clog2(SETTLE_CYC + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic tick
);
    logic [CYC_W-1:0] remain;
    logic             running;

    assign tick = running && (remain == '0);

    // Load on start, count down while running, stop at zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain  <= '0;
            running <= 1'b0;
        end else if (start) begin
            remain  <= CYC_W'(SETTLE_CYC - 1);
            running <= 1'b1;
        end else if (tick) begin
            running <= 1'b0;
        end else if (running) begin
            remain <= remain - 1'b1;
        end
    end
endmodule

// File: rtl/pad_rail_bank.sv
// Rail bank: one flop per domain control, reset to 1 (domain off).
// A write sets or clears exactly the selected rail.
module pad_rail_bank #(
    parameter int NUM = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr,
    input  logic [1:0]     sel,
    input  logic           val,
    output logic [NUM-1:0] rails
);
    for (genvar g = 0; g < NUM; g++) begin : g_rail
        // Hold the rail unless this bit is the write target.
        always_ff @(posedge clk) begin
            if (!rst_n)
                rails[g] <= 1'b1;
            else if (wr && (int'(sel) == g))
                rails[g] <= val;
        end
    end
endmodule

// File: rtl/pad_use_counter.sv
// Use counter: holds the number of active PHY users, with flags for the
// sequencing and guard decisions. Assumes the caller never asks for inc
// at full or dec at zero.
module pad_use_counter #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    input  logic             dec,
    output logic [CNT_W-1:0] count,
    output logic             is_zero,
    output logic             is_one,
    output logic             is_full
);
    assign is_zero = (count == '0);
    assign is_one  = (count == CNT_W'(1));
    assign is_full = (count == '1);

    // Step the count by one on inc or dec.
    always_ff @(posedge clk) begin
        if (!rst_n)
            count <= '0;
        else if (inc && !dec)
            count <= count + 1'b1;
        else if (dec && !inc)
            count <= count - 1'b1;
    end
endmodule

// File: rtl/pad_pwr_seq.sv
// Reference-counted pad power sequencer (top).
// Takes one enable/disable request at a time and runs the domain sequence
// only on the first enable and the last disable. It hands the per-PHY
// step to outside logic through phy_start/phy_done.
// Assumes phy_done arrives only after phy_start, once per start.
module pad_pwr_seq
    import pad_pwr_pkg::*;
#(
    parameter int CLK_MHZ   = 200,
    parameter int SETTLE_US = 100,
    parameter int CNT_W     = 4,
    localparam int SETTLE_CYC = CLK_MHZ * SETTLE_US
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic             req_enable,
    input  logic [1:0]       req_phy_id,
    output logic             phy_start,
    output logic             phy_on,
    output logic [1:0]       phy_sel,
    input  logic             phy_done,
    input  logic             phy_fail,
    output logic             rail_vcore_down,
    output logic             rail_clamp_early,
    output logic             rail_clamp,
    output logic             busy,
    output logic             done,
    output logic             error,
    output logic [CNT_W-1:0] use_count
);
    seq_state_t           state;
    logic                 cur_en;
    logic [1:0]           cur_id;
    logic                 dir_up;
    logic [1:0]           step;
    logic                 err_q;
    logic                 tick;
    logic                 tmr_start;
    logic                 rail_wr;
    logic                 cnt_inc;
    logic                 cnt_dec;
    logic                 cnt_zero;
    logic                 cnt_one;
    logic                 cnt_full;
    logic [NUM_RAILS-1:0] rails;
    logic                 last_step;
    logic                 phy_ok;
    logic                 reject;

    assign last_step = (step == 2'(LAST_STEP));
    assign phy_ok    = (state == ST_PHY_WAIT) && phy_done && !phy_fail;
    assign reject    = !phy_id_known(req_phy_id) ||
                       (req_enable ? cnt_full : cnt_zero);

    // Handshake and status decode from the sequencer state.
    always_comb begin
        req_ready = (state == ST_IDLE);
        busy      = (state != ST_IDLE);
        done      = (state == ST_RESP);
        error     = (state == ST_RESP) && err_q;
        phy_start = (state == ST_PHY_GO);
        phy_on    = cur_en;
        phy_sel   = cur_id;
        rail_wr   = (state == ST_STEP);
        tmr_start = (state == ST_STEP);
        cnt_inc   = phy_ok && cur_en;
        cnt_dec   = (phy_ok && !cur_en && !cnt_one) ||
                    ((state == ST_SETTLE) && tick && last_step && !dir_up);
    end

    // Sequencer: request intake, domain steps, PHY handoff, response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            cur_en <= 1'b0;
            cur_id <= '0;
            dir_up <= 1'b1;
            step   <= '0;
            err_q  <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        cur_en <= req_enable;
                        cur_id <= req_phy_id;
                        step   <= '0;
                        dir_up <= 1'b1;
                        err_q  <= reject;
                        if (reject)
                            state <= ST_RESP;
                        else if (req_enable && cnt_zero)
                            state <= ST_STEP;
                        else
                            state <= ST_PHY_GO;
                    end
                end
                ST_STEP:   state <= ST_SETTLE;
                ST_SETTLE: begin
                    if (tick) begin
                        if (!last_step) begin
                            step  <= step + 1'b1;
                            state <= ST_STEP;
                        end else begin
                            state <= dir_up ? ST_PHY_GO : ST_RESP;
                        end
                    end
                end
                ST_PHY_GO: state <= ST_PHY_WAIT;
                ST_PHY_WAIT: begin
                    if (phy_done) begin
                        if (phy_fail) begin
                            err_q <= 1'b1;
                            state <= ST_RESP;
                        end else if (!cur_en && cnt_one) begin
                            dir_up <= 1'b0;
                            step   <= '0;
                            state  <= ST_STEP;
                        end else begin
                            state <= ST_RESP;
                        end
                    end
                end
                default:   state <= ST_IDLE;
            endcase
        end
    end

    pad_settle_timer #(.SETTLE_CYC(SETTLE_CYC)) i_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (tmr_start),
        .tick  (tick)
    );

    pad_rail_bank #(.NUM(NUM_RAILS)) i_rails (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (rail_wr),
        .sel   (rail_of_step(dir_up, step)),
        .val   (!dir_up),
        .rails (rails)
    );

    pad_use_counter #(.CNT_W(CNT_W)) i_count (
        .clk     (clk),
        .rst_n   (rst_n),
        .inc     (cnt_inc),
        .dec     (cnt_dec),
        .count   (use_count),
        .is_zero (cnt_zero),
        .is_one  (cnt_one),
        .is_full (cnt_full)
    );

    assign rail_clamp       = rails[RAIL_CLAMP];
    assign rail_clamp_early = rails[RAIL_EARLY];
    assign rail_vcore_down  = rails[RAIL_VCORE];
endmodule

// File: rtl/pad_pwr_seq_chk.sv
// Protocol checker for pad_pwr_seq, attached by bind.
// Checks rail ordering, count steps and handshake relations at the ports.
module pad_pwr_seq_chk #(
    parameter int CNT_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_ready,
    input logic             phy_start,
    input logic             phy_on,
    input logic             rail_vcore_down,
    input logic             rail_clamp_early,
    input logic             rail_clamp,
    input logic             busy,
    input logic             done,
    input logic             error,
    input logic [CNT_W-1:0] use_count
);
    // R2: core voltage only comes up once both clamps are released.
    p_vcore_last_up_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rail_vcore_down) |-> (!rail_clamp && !rail_clamp_early));

    // R2: early clamp released only after the clamp.
    p_early_after_clamp_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rail_clamp_early) |-> !rail_clamp);

    // R3: clamp engaged only once voltage is down and early clamp is set.
    p_clamp_last_down_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rail_clamp) |-> (rail_vcore_down && rail_clamp_early));

    // R3: early clamp set only once voltage is down.
    p_early_after_vcore_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rail_clamp_early) |-> rail_vcore_down);

    // R6: a PHY bring-up only starts with the domain fully up.
    p_domain_up_at_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (phy_start && phy_on) |-> (!rail_vcore_down && !rail_clamp_early && !rail_clamp));

    // R8: a failed or rejected request leaves the count where it was.
    p_err_keeps_count_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && error) |-> $stable(use_count));

    // R9: the count moves by at most one per cycle and never wraps.
    p_count_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(use_count) |->
            ((use_count == $past(use_count) + 1'b1 && $past(use_count) != '1) ||
             (use_count == $past(use_count) - 1'b1 && $past(use_count) != '0)));

    // R10: rails only move while a request is in progress.
    p_rails_only_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable({rail_vcore_down, rail_clamp_early, rail_clamp}) |-> $past(busy));

    // R10: done is a single-cycle pulse followed by ready.
    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && req_ready));

    // R10: ready and busy never overlap.
    p_ready_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_ready && busy));
endmodule

bind pad_pwr_seq pad_pwr_seq_chk #(.CNT_W(CNT_W)) i_pad_pwr_seq_chk (
    .clk              (clk),
    .rst_n            (rst_n),
    .req_ready        (req_ready),
    .phy_start        (phy_start),
    .phy_on           (phy_on),
    .rail_vcore_down  (rail_vcore_down),
    .rail_clamp_early (rail_clamp_early),
    .rail_clamp       (rail_clamp),
    .busy             (busy),
    .done             (done),
    .error            (error),
    .use_count        (use_count)
);

// File: tb/test_pad_pwr_seq.sv
// Directed bench for pad_pwr_seq: one task per scenario, each self-checking.
module test_pad_pwr_seq;
    localparam int CLK_MHZ   = 200;
    localparam int SETTLE_US = 1;
    localparam int CNT_W     = 2;
    localparam int SETTLE    = CLK_MHZ * SETTLE_US;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             req_valid = 1'b0;
    logic             req_enable = 1'b0;
    logic [1:0]       req_phy_id = '0;
    logic             phy_done = 1'b0;
    logic             phy_fail = 1'b0;
    logic             req_ready, phy_start, phy_on, busy, done, error;
    logic [1:0]       phy_sel;
    logic             rail_vcore_down, rail_clamp_early, rail_clamp;
    logic [CNT_W-1:0] use_count;

    int  n_checks = 0;
    int  n_fail = 0;
    int  cyc = 0;
    bit  fail_mode = 1'b0;
    int  n_starts = 0;
    int  t_start = 0;
    bit  last_on;
    logic [1:0] last_sel;
    int  n_rail = 0;
    int  t_clamp = 0, t_early = 0, t_vcore = 0;
    bit  saw_busy_not_ready;
    int  n_done_in_req;
    bit  got_err;

    always #2.5 clk = ~clk;

    pad_pwr_seq #(.CLK_MHZ(CLK_MHZ), .SETTLE_US(SETTLE_US), .CNT_W(CNT_W)) i_pad_pwr_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_enable(req_enable), .req_phy_id(req_phy_id), .phy_start(phy_start),
        .phy_on(phy_on), .phy_sel(phy_sel), .phy_done(phy_done), .phy_fail(phy_fail),
        .rail_vcore_down(rail_vcore_down), .rail_clamp_early(rail_clamp_early),
        .rail_clamp(rail_clamp), .busy(busy), .done(done), .error(error),
        .use_count(use_count)
    );

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // PHY model: answer each start after a few cycles.
    initial begin
        forever begin
            @(negedge clk);
            if (phy_start) begin
                n_starts++;
                t_start  = cyc;
                last_on  = phy_on;
                last_sel = phy_sel;
                repeat (3) @(negedge clk);
                phy_done = 1'b1;
                phy_fail = fail_mode;
                @(negedge clk);
                phy_done = 1'b0;
                phy_fail = 1'b0;
            end
        end
    end

    // Rail monitor: timestamp every rail change.
    initial begin
        logic [2:0] prev;
        prev = 3'b111;
        forever begin
            @(negedge clk);
            if (rail_clamp != prev[0]) begin n_rail++; t_clamp = cyc; end
            if (rail_clamp_early != prev[1]) begin n_rail++; t_early = cyc; end
            if (rail_vcore_down != prev[2]) begin n_rail++; t_vcore = cyc; end
            prev = {rail_vcore_down, rail_clamp_early, rail_clamp};
        end
    end

    // Issue one request and wait for its done pulse.
    task automatic do_req(input bit en, input logic [1:0] id);
        int guard;
        saw_busy_not_ready = 1'b0;
        n_done_in_req = 0;
        @(negedge clk);
        req_valid  = 1'b1;
        req_enable = en;
        req_phy_id = id;
        @(negedge clk);
        req_valid = 1'b0;
        guard = 0;
        while (!done && guard < 5000) begin
            if (busy && !req_ready) saw_busy_not_ready = 1'b1;
            @(negedge clk);
            guard++;
        end
        got_err = error;
        while (done) begin n_done_in_req++; @(negedge clk); end
    endtask

    task automatic t_reset;
        check(rail_vcore_down && rail_clamp_early && rail_clamp, "R1 rails off", {rail_vcore_down, rail_clamp_early, rail_clamp}, 7);
        check(use_count == 0, "R1 count", use_count, 0);
        check(req_ready && !busy, "R1 ready", {req_ready, busy}, 2);
    endtask

    task automatic t_first_enable;
        int s0;
        s0 = n_starts;
        do_req(1'b1, 2'd0);
        check(!got_err, "R2 no error", got_err, 0);
        check(t_clamp < t_early && t_early < t_vcore, "R2 order", t_early, t_vcore);
        check(t_early - t_clamp >= SETTLE && t_vcore - t_early >= SETTLE, "R2 spacing", t_vcore - t_early, SETTLE);
        check(n_starts == s0 + 1 && last_on && last_sel == 2'd0, "R6 start pcie", last_sel, 0);
        check(t_start - t_vcore >= SETTLE, "R6 domain before phy", t_start - t_vcore, SETTLE);
        check(use_count == 1, "R2 count", use_count, 1);
        check(saw_busy_not_ready && n_done_in_req == 1, "R10 handshake", n_done_in_req, 1);
    endtask

    task automatic t_second_enable;
        int r0;
        r0 = n_rail;
        do_req(1'b1, 2'd1);
        check(n_rail == r0, "R4 no rail change", n_rail, r0);
        check(last_on && last_sel == 2'd1, "R4 start sata", last_sel, 1);
        check(use_count == 2 && !got_err, "R4 count", use_count, 2);
    endtask

    task automatic t_second_disable;
        int r0;
        r0 = n_rail;
        do_req(1'b0, 2'd1);
        check(n_rail == r0, "R5 no rail change", n_rail, r0);
        check(!last_on && use_count == 1 && !got_err, "R5 count", use_count, 1);
    endtask

    task automatic t_last_disable;
        int r0;
        r0 = n_rail;
        do_req(1'b0, 2'd0);
        check(n_rail == r0 + 3 && !got_err, "R3 three changes", n_rail, r0 + 3);
        check(t_vcore < t_early && t_early < t_clamp, "R3 order", t_early, t_clamp);
        check(t_clamp - t_early >= SETTLE && t_early - t_vcore >= SETTLE, "R3 spacing", t_clamp - t_early, SETTLE);
        check(t_vcore > t_start && !last_on, "R6 phy before domain", t_vcore, t_start);
        check(rail_vcore_down && rail_clamp_early && rail_clamp, "R3 rails off", {rail_vcore_down, rail_clamp_early, rail_clamp}, 7);
        check(use_count == 0, "R3 count", use_count, 0);
    endtask

    task automatic t_bad_ids;
        int s0, r0;
        for (int id = 2; id < 4; id++) begin
            s0 = n_starts; r0 = n_rail;
            do_req(1'b1, 2'(id));
            check(got_err, "R7 reject id", got_err, 1);
            check(n_starts == s0 && n_rail == r0 && use_count == 0, "R7 no effect", n_starts - s0, 0);
        end
    endtask

    task automatic t_underflow_overflow;
        int s0, r0;
        s0 = n_starts; r0 = n_rail;
        do_req(1'b0, 2'd0);
        check(got_err && use_count == 0 && n_starts == s0 && n_rail == r0, "R9 disable at zero", use_count, 0);
        for (int k = 0; k < 3; k++) do_req(1'b1, 2'(k % 2));
        check(use_count == 3, "R9 filled", use_count, 3);
        s0 = n_starts; r0 = n_rail;
        do_req(1'b1, 2'd0);
        check(got_err && use_count == 3 && n_starts == s0 && n_rail == r0, "R9 enable at max", use_count, 3);
        for (int k = 0; k < 3; k++) do_req(1'b0, 2'd0);
        check(use_count == 0 && rail_clamp, "R9 drained", use_count, 0);
    endtask

    task automatic t_phy_fail;
        int r0;
        fail_mode = 1'b1;
        do_req(1'b1, 2'd1);
        check(got_err && use_count == 0, "R8 fail on enable", use_count, 0);
        fail_mode = 1'b0;
        do_req(1'b1, 2'd1);
        check(!got_err && use_count == 1, "R8 recover", use_count, 1);
        fail_mode = 1'b1;
        r0 = n_rail;
        do_req(1'b0, 2'd1);
        check(got_err && use_count == 1 && n_rail == r0, "R8 fail on disable", use_count, 1);
        fail_mode = 1'b0;
        do_req(1'b0, 2'd1);
        check(use_count == 0 && rail_vcore_down, "R8 cleanup", use_count, 0);
    endtask

    task automatic finish_run;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_first_enable();
        t_second_enable();
        t_second_disable();
        t_last_disable();
        t_bad_ids();
        t_underflow_overflow();
        t_phy_fail();
        finish_run();
    end
endmodule